// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is the control logic that sits in front of an analog-to-digital converter core. Software writes a control word that holds a start bit, a scan mode (single or multi), a group select and a channel select. Instead of writing the start bit, an external trigger pin can launch the same run. The sequencer then drives the converter core through a start/done handshake, one channel at a time. Each returned sample goes into the result register for that channel. The block clears its run bit when the work is finished, latches an end flag and can raise an interrupt.

There are eight channels. The channel index is the group bit followed by the two-bit channel select, so group 0 covers channels 0 to 3 and group 1 covers channels 4 to 7. In single mode only the addressed channel is converted. In multi mode the block converts every channel from the first channel of the group up to the addressed channel, in ascending order. If software writes 0 to the start bit during a run, the run is aborted, the core is told to drop its conversion, and a later start begins again at the first channel of the group.

Top module: `adc_scan_seq`

## Requirements
- R1: A control write with `ctl_start`=1 while no run is active starts a run: `run_active` reads 1 and `conv_start` is high for exactly one cycle, in the cycle after the write. A control write with `ctl_start`=0 while idle starts nothing.
- R2: A rising edge on `ext_trig`, seen after a two-flop synchronizer, starts a run with the stored configuration when idle. Edges that arrive during a run are dropped, and a trigger held high starts nothing more.
- R3: In multi mode (`ctl_multi`=1) the channels {grp,0} through {grp,chan} are converted in ascending order. Each later `conv_start` is raised in the cycle right after the previous `conv_done`.
- R4: In single mode (`ctl_multi`=0) only channel {grp,chan} is converted. The other result registers keep their contents.
- R5: Each `conv_data` sample is stored in the result register whose index equals the channel converted. `rd_data` shows register `rd_sel` without delay. All result registers reset to 0.
- R6: In the cycle after the last `conv_done` of a run, `run_active` returns to 0 and `end_flag` becomes 1.
- R7: A control write with `ctl_start`=0 during a run aborts it: `run_active` drops, `conv_abort` pulses for one cycle, no further sample is stored, no further channel is started and `end_flag` is not set.
- R8: A start after an abort begins at the first channel of the group.
- R9: The mode, group and channel fields of a write that sets the start bit apply to the run that write begins. Writes made during a run update the readback outputs `cfg_*` but do not change that run. A start write during a run does not abort it.
- R10: `end_flag` stays 1 until a `flag_we` write of 0 that follows a `flag_rd` made while the flag was 1. A clear without such a read is ignored, each read permits only one clear, writing 1 has no effect, and a hardware set in the same cycle as a clear wins.
- R11: `irq` equals `end_flag` AND the stored interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctl_we | input | 1 | Control word write strobe |
| ctl_start | input | 1 | Start bit value written |
| ctl_multi | input | 1 | Scan mode: 0 single, 1 multi |
| ctl_grp | input | 1 | Group select (channel index MSB) |
| ctl_chan | input | 2 | Channel select within the group |
| ctl_ie | input | 1 | Interrupt enable value written |
| flag_rd | input | 1 | Status read strobe (arms the flag clear) |
| flag_we | input | 1 | Status write strobe |
| flag_wdata | input | 1 | End flag value written (only 0 acts) |
| ext_trig | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_abort | output | 1 | One-cycle pulse telling the core to drop its conversion |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | Core reports a finished conversion |
| conv_data | input | 10 | Sample from the core, valid with conv_done |
| rd_sel | input | 3 | Result register select |
| rd_data | output | 10 | Selected result register |
| run_active | output | 1 | Start bit readback (1 while a run is in progress) |
| end_flag | output | 1 | End-of-run flag |
| irq | output | 1 | Interrupt request |
| cfg_multi | output | 1 | Stored mode readback |
| cfg_grp | output | 1 | Stored group readback |
| cfg_chan | output | 2 | Stored channel readback |
| cfg_ie | output | 1 | Stored interrupt enable readback |

## Verification
The bench aborts a multi run after its second channel has started. A sequencer that does not really stop would then raise a third start, store the late sample or set the end flag. The restart that follows must begin at channel 0, so a design that resumes from the interrupted channel is caught. A second start written during a run, carrying a different group and mode, has to leave the run at its original two channels, which exposes a design that reads the live configuration or treats the write as a restart. The flag clear is driven in the same cycle as a hardware set, and without a prior read, which catches wrong priority and clears that need no read. A trigger that toggles during a run, or that stays high after the run, must not produce any extra conversions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CONV = 2'd1
  } sq_state_e;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_MULTI  = 1'b1
  } scan_mode_e;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async_i,
  output logic trig_rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;
  logic              last_q;

  // shift chain: stage 0 samples the pin, later stages follow
  always_comb begin
    sync_n = {sync_q[STAGES-2:0], trig_async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign trig_rise_o = sync_q[STAGES-1] & ~last_q;

  AST_TRIG_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise_o |=> !trig_rise_o); // R2

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int GRP_W = 1,
  parameter int CH_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_sw_i,
  input  logic                  trig_rise_i,
  input  logic                  abort_req_i,
  input  logic                  mode_multi_i,
  input  logic [GRP_W-1:0]      grp_i,
  input  logic [CH_W-1:0]       chan_i,
  input  logic                  conv_done_i,
  output logic                  busy_o,
  output logic                  conv_start_o,
  output logic                  conv_abort_o,
  output logic [GRP_W+CH_W-1:0] conv_ch_o,
  output logic                  res_we_o,
  output logic [GRP_W+CH_W-1:0] res_idx_o,
  output logic                  run_end_o
);

  localparam int IDX_W = GRP_W + CH_W;
  localparam logic [IDX_W-1:0] STEP = {{(IDX_W-1){1'b0}}, 1'b1};

  sq_state_e        state_q, state_n;
  logic [IDX_W-1:0] cur_q, cur_n;
  logic [IDX_W-1:0] last_q, last_n;
  logic             start_q, start_n;
  logic             abort_q, abort_n;
  logic             go;
  logic [IDX_W-1:0] first_idx;
  scan_mode_e       mode;

  assign mode      = scan_mode_e'(mode_multi_i);
  assign go        = (go_sw_i | trig_rise_i) & (state_q == SQ_IDLE);
  assign first_idx = (mode == MODE_MULTI) ? {grp_i, {CH_W{1'b0}}} : {grp_i, chan_i};

  always_comb begin
    state_n = state_q;
    cur_n   = cur_q;
    last_n  = last_q;
    start_n = 1'b0;
    abort_n = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (go) begin
          state_n = SQ_CONV;
          cur_n   = first_idx;
          last_n  = {grp_i, chan_i};
          start_n = 1'b1;
        end
      end
      SQ_CONV: begin
        if (abort_req_i) begin
          state_n = SQ_IDLE;
          abort_n = 1'b1;
        end else if (conv_done_i) begin
          if (cur_q == last_q) begin
            state_n = SQ_IDLE;
          end else begin
            cur_n   = cur_q + STEP;
            start_n = 1'b1;
          end
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_n;
      cur_q   <= cur_n;
      last_q  <= last_n;
      start_q <= start_n;
      abort_q <= abort_n;
    end
  end

  assign busy_o       = (state_q == SQ_CONV);
  assign conv_start_o = start_q;
  assign conv_abort_o = abort_q;
  assign conv_ch_o    = cur_q;
  assign res_we_o     = busy_o & conv_done_i & ~abort_req_i;
  assign res_idx_o    = cur_q;
  assign run_end_o    = res_we_o & (cur_q == last_q);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o); // R1

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && conv_done_i && !abort_req_i && cur_q != last_q) |=> (conv_start_o && busy_o)); // R3

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !conv_done_i && !abort_req_i) |=> (busy_o && $stable(cur_q) && $stable(last_q))); // R9

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_req_i) |=> (!busy_o && conv_abort_o && !conv_start_o)); // R7

  AST_LAST_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_end_o |=> (!busy_o && !conv_start_o)); // R6

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int DATA_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [IDX_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int NUM = 1 << IDX_W;

  logic [DATA_W-1:0] res_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_res
    logic              en;
    logic [DATA_W-1:0] res_n;

    assign en = we_i & (idx_i == IDX_W'(g));

    always_comb begin
      res_n = res_q[g];
      if (en) res_n = din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q[g] <= '0;
      else        res_q[g] <= res_n;
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && idx_i == IDX_W'(g)) |=> $stable(res_q[g])); // R5

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && idx_i == IDX_W'(g)) |=> (res_q[g] == $past(din_i))); // R5
  end

  assign rd_data_o = res_q[rd_sel_i];

endmodule

// File: rtl/adc_end_flag.sv
module adc_end_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic we_i,
  input  logic wdata_i,
  output logic flag_o
);

  logic flag_q, flag_n;
  logic armed_q, armed_n;

  always_comb begin
    flag_n  = flag_q;
    armed_n = armed_q;
    if (rd_i && flag_q) armed_n = 1'b1;
    if (we_i && !wdata_i) begin
      if (armed_q) flag_n = 1'b0;
      armed_n = 1'b0;
    end
    if (set_i) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      armed_q <= armed_n;
    end
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R10

  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q) |=> flag_q); // R10

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int DATA_W = 10,
  parameter int GRP_W  = 1,
  parameter int CH_W   = 2,
  parameter int SYNC_N = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_we,
  input  logic                  ctl_start,
  input  logic                  ctl_multi,
  input  logic [GRP_W-1:0]      ctl_grp,
  input  logic [CH_W-1:0]       ctl_chan,
  input  logic                  ctl_ie,
  input  logic                  flag_rd,
  input  logic                  flag_we,
  input  logic                  flag_wdata,
  input  logic                  ext_trig,
  output logic                  conv_start,
  output logic                  conv_abort,
  output logic [GRP_W+CH_W-1:0] conv_ch,
  input  logic                  conv_done,
  input  logic [DATA_W-1:0]     conv_data,
  input  logic [GRP_W+CH_W-1:0] rd_sel,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  run_active,
  output logic                  end_flag,
  output logic                  irq,
  output logic                  cfg_multi,
  output logic [GRP_W-1:0]      cfg_grp,
  output logic [CH_W-1:0]       cfg_chan,
  output logic                  cfg_ie
);

  localparam int IDX_W = GRP_W + CH_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // stored configuration fields
  logic             multi_q, multi_n;
  logic [GRP_W-1:0] grp_q, grp_n;
  logic [CH_W-1:0]  chan_q, chan_n;
  logic             ie_q, ie_n;

  always_comb begin
    multi_n = multi_q;
    grp_n   = grp_q;
    chan_n  = chan_q;
    ie_n    = ie_q;
    if (ctl_we) begin
      multi_n = ctl_multi;
      grp_n   = ctl_grp;
      chan_n  = ctl_chan;
      ie_n    = ctl_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      multi_q <= 1'b0;
      grp_q   <= '0;
      chan_q  <= '0;
      ie_q    <= 1'b0;
    end else begin
      multi_q <= multi_n;
      grp_q   <= grp_n;
      chan_q  <= chan_n;
      ie_q    <= ie_n;
    end
  end

  logic             trig_rise;
  logic             go_sw;
  logic             abort_req;
  logic             busy;
  logic             res_we;
  logic [IDX_W-1:0] res_idx;
  logic             run_end;

  assign go_sw     = ctl_we & ctl_start;
  assign abort_req = ctl_we & ~ctl_start;

  adc_trig_sync #(
    .STAGES (SYNC_N)
  ) u_trig (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .trig_async_i (ext_trig),
    .trig_rise_o  (trig_rise)
  );

  // configuration seen by a starting run is the one being written, if any
  adc_seq_ctrl #(
    .GRP_W (GRP_W),
    .CH_W  (CH_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .go_sw_i      (go_sw),
    .trig_rise_i  (trig_rise),
    .abort_req_i  (abort_req),
    .mode_multi_i (multi_n),
    .grp_i        (grp_n),
    .chan_i       (chan_n),
    .conv_done_i  (conv_done),
    .busy_o       (busy),
    .conv_start_o (conv_start),
    .conv_abort_o (conv_abort),
    .conv_ch_o    (conv_ch),
    .res_we_o     (res_we),
    .res_idx_o    (res_idx),
    .run_end_o    (run_end)
  );

  adc_result_bank #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .we_i      (res_we),
    .idx_i     (res_idx),
    .din_i     (conv_data),
    .rd_sel_i  (rd_sel),
    .rd_data_o (rd_data)
  );

  adc_end_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_i   (run_end),
    .rd_i    (flag_rd),
    .we_i    (flag_we),
    .wdata_i (flag_wdata),
    .flag_o  (end_flag)
  );

  assign run_active = busy;
  assign irq        = end_flag & ie_q;
  assign cfg_multi  = multi_q;
  assign cfg_grp    = grp_q;
  assign cfg_chan   = chan_q;
  assign cfg_ie     = ie_q;

  AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    run_end |=> (end_flag && !run_active)); // R6

  AST_ABORT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_active && abort_req) |=> (!run_active && !res_we)); // R7

  AST_TRIG_BUSY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_active && trig_rise && !conv_done && !ctl_we) |=> (run_active && !conv_start)); // R2

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam int DW  = 10;
  localparam int GW  = 1;
  localparam int CW  = 2;
  localparam int IW  = GW + CW;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0, ctl_start = 1'b0, ctl_multi = 1'b0, ctl_ie = 1'b0;
  logic [GW-1:0] ctl_grp = '0;
  logic [CW-1:0] ctl_chan = '0;
  logic          flag_rd = 1'b0, flag_we = 1'b0, flag_wdata = 1'b0;
  logic          ext_trig = 1'b0;
  logic          conv_start, conv_abort, conv_done;
  logic [IW-1:0] conv_ch;
  logic [DW-1:0] conv_data;
  logic [IW-1:0] rd_sel = '0;
  logic [DW-1:0] rd_data;
  logic          run_active, end_flag, irq, cfg_multi, cfg_ie;
  logic [GW-1:0] cfg_grp;
  logic [CW-1:0] cfg_chan;

  always #4 clk = ~clk;

  adc_scan_seq #(.DATA_W(DW), .GRP_W(GW), .CH_W(CW), .SYNC_N(2)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
    .ctl_multi(ctl_multi), .ctl_grp(ctl_grp), .ctl_chan(ctl_chan), .ctl_ie(ctl_ie),
    .flag_rd(flag_rd), .flag_we(flag_we), .flag_wdata(flag_wdata), .ext_trig(ext_trig),
    .conv_start(conv_start), .conv_abort(conv_abort), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .run_active(run_active), .end_flag(end_flag), .irq(irq), .cfg_multi(cfg_multi),
    .cfg_grp(cfg_grp), .cfg_chan(cfg_chan), .cfg_ie(cfg_ie));

  int total = 0;
  int bad   = 0;
  int seed  = 0;

  // converter core model
  int            m_cnt  = 0;
  logic          m_done = 1'b0;
  logic [DW-1:0] m_data = '0;
  logic [IW-1:0] m_ch   = '0;
  assign conv_done = m_done;
  assign conv_data = m_data;

  always @(posedge clk) begin
    m_done <= 1'b0;
    if (conv_start) begin
      m_cnt <= LAT;
      m_ch  <= conv_ch;
    end else if (conv_abort) begin
      m_cnt <= 0;
    end else if (m_cnt != 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) begin
        m_done <= 1'b1;
        m_data <= DW'(seed * 8 + int'(m_ch));
      end
    end
  end

  // start log and gap monitor
  logic [IW-1:0] log_ch [16];
  int   log_n     = 0;
  int   gap_err   = 0;
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (conv_start) begin
      if (log_n > 0 && !prev_done) gap_err++;
      if (log_n < 16) log_ch[log_n] = conv_ch;
      log_n++;
    end
    prev_done = conv_done;
  end

  function automatic int cval(input int s, input int ch);
    return (s * 8 + ch) & ((1 << DW) - 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk);
    #1;
    log_n   = 0;
    gap_err = 0;
  endtask

  task automatic ctl_write(input logic st, input logic mu, input logic [GW-1:0] g,
                           input logic [CW-1:0] c, input logic ie);
    @(negedge clk);
    ctl_we = 1'b1; ctl_start = st; ctl_multi = mu; ctl_grp = g; ctl_chan = c; ctl_ie = ie;
    @(negedge clk);
    ctl_we = 1'b0; ctl_start = 1'b0;
  endtask

  task automatic flag_read();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic flag_write(input logic v);
    @(negedge clk); flag_we = 1'b1; flag_wdata = v;
    @(negedge clk); flag_we = 1'b0;
  endtask

  task automatic clr_flag();
    flag_read();
    flag_write(1'b0);
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 400 && run_active; i++) @(negedge clk);
    chk(req, "run ends", int'(run_active), 0);
  endtask

  task automatic rd_chk(input string req, input int idx, input int exp);
    @(negedge clk);
    rd_sel = IW'(idx);
    #1;
    chk(req, $sformatf("result reg %0d", idx), int'(rd_data), exp);
  endtask

  task automatic chk_run(input string req, input int first, input int n);
    chk(req, "starts in run", log_n, n);
    for (int i = 0; i < n && i < 16; i++)
      chk(req, $sformatf("channel of start %0d", i), int'(log_ch[i]), first + i);
    chk(req, "idle cycles between channels", gap_err, 0);
  endtask

  task automatic t_reset();
    chk("R1", "run_active after reset", int'(run_active), 0);
    chk("R6", "end_flag after reset", int'(end_flag), 0);
    chk("R11", "irq after reset", int'(irq), 0);
    chk("R1", "conv_start after reset", int'(conv_start), 0);
    chk("R9", "cfg after reset", int'({cfg_multi, cfg_grp, cfg_chan, cfg_ie}), 0);
    rd_chk("R5", 0, 0);
    rd_chk("R5", 7, 0);
  endtask

  task automatic t_multi_full();
    clear_log();
    seed = 1;
    ctl_write(1'b1, 1'b1, 1'b0, 2'd3, 1'b1);
    chk("R1", "run_active after start write", int'(run_active), 1);
    chk("R1", "conv_start after start write", int'(conv_start), 1);
    chk("R1", "first channel", int'(conv_ch), 0);
    wait_idle("R6");
    chk("R6", "end_flag at end", int'(end_flag), 1);
    chk_run("R3", 0, 4);
    for (int i = 0; i < 4; i++) rd_chk("R5", i, cval(1, i));
    chk("R11", "irq with ie=1", int'(irq), 1);
  endtask

  task automatic t_flag_rules();
    flag_write(1'b0);
    chk("R10", "clear without read ignored", int'(end_flag), 1);
    flag_read();
    flag_write(1'b1);
    chk("R10", "writing 1 no effect", int'(end_flag), 1);
    flag_read();
    flag_write(1'b0);
    chk("R10", "clear after read", int'(end_flag), 0);
    chk("R11", "irq follows flag", int'(irq), 0);
  endtask

  task automatic t_single();
    clear_log();
    seed = 2;
    ctl_write(1'b1, 1'b0, 1'b1, 2'd2, 1'b1);
    wait_idle("R4");
    chk_run("R4", 6, 1);
    rd_chk("R4", 6, cval(2, 6));
    rd_chk("R4", 4, 0);
    rd_chk("R4", 5, 0);
    rd_chk("R4", 7, 0);
    chk("R6", "end_flag after single", int'(end_flag), 1);
  endtask

  task automatic t_multi_grp1();
    clear_log();
    seed = 3;
    ctl_write(1'b1, 1'b1, 1'b1, 2'd1, 1'b1);
    wait_idle("R3");
    chk_run("R3", 4, 2);
    rd_chk("R5", 4, cval(3, 4));
    rd_chk("R5", 5, cval(3, 5));
    rd_chk("R5", 6, cval(2, 6));
  endtask

  task automatic t_abort_restart();
    clr_flag();
    clear_log();
    seed = 4;
    ctl_write(1'b1, 1'b1, 1'b0, 2'd3, 1'b1);
    for (int i = 0; i < 200 && log_n < 2; i++) @(negedge clk);
    ctl_write(1'b0, 1'b1, 1'b0, 2'd3, 1'b1);
    chk("R7", "run_active after abort", int'(run_active), 0);
    chk("R7", "conv_abort pulse", int'(conv_abort), 1);
    @(negedge clk);
    chk("R7", "conv_abort one cycle", int'(conv_abort), 0);
    repeat (30) @(negedge clk);
    chk("R7", "no start after abort", log_n, 2);
    chk("R7", "no end flag on abort", int'(end_flag), 0);
    rd_chk("R7", 0, cval(4, 0));
    rd_chk("R7", 1, cval(1, 1));
    rd_chk("R7", 2, cval(1, 2));
    clear_log();
    seed = 5;
    ctl_write(1'b1, 1'b1, 1'b0, 2'd3, 1'b1);
    chk("R8", "restart at group start", int'(conv_ch), 0);
    wait_idle("R8");
    chk_run("R8", 0, 4);
    rd_chk("R8", 3, cval(5, 3));
  endtask

  task automatic t_cfg_busy();
    clr_flag();
    clear_log();
    seed = 6;
    ctl_write(1'b1, 1'b1, 1'b0, 2'd1, 1'b1);
    ctl_write(1'b1, 1'b0, 1'b1, 2'd3, 1'b0);
    chk("R9", "start write keeps run", int'(run_active), 1);
    wait_idle("R9");
    chk_run("R9", 0, 2);
    chk("R9", "cfg_grp readback", int'(cfg_grp), 1);
    chk("R9", "cfg_chan readback", int'(cfg_chan), 3);
    chk("R9", "cfg_multi readback", int'(cfg_multi), 0);
    rd_chk("R9", 1, cval(6, 1));
    rd_chk("R9", 7, 0);
    chk("R11", "irq with ie=0", int'(irq), 0);
  endtask

  task automatic t_set_beats_clear();
    flag_read();
    clear_log();
    seed = 8;
    ctl_write(1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    for (int i = 0; i < 200 && !m_done; i++) @(negedge clk);
    flag_we = 1'b1; flag_wdata = 1'b0;
    @(negedge clk);
    flag_we = 1'b0;
    chk("R10", "set beats clear", int'(end_flag), 1);
    flag_write(1'b0);
    chk("R10", "one read one clear", int'(end_flag), 1);
    clr_flag();
    chk("R10", "clear after new read", int'(end_flag), 0);
  endtask

  task automatic t_trigger();
    clear_log();
    ctl_write(1'b0, 1'b1, 1'b1, 2'd3, 1'b1);
    repeat (4) @(negedge clk);
    chk("R1", "start=0 idle write no run", int'(run_active), 0);
    chk("R1", "start=0 idle write no start", log_n, 0);
    seed = 7;
    @(negedge clk);
    ext_trig = 1'b1;
    for (int i = 0; i < 50 && log_n < 1; i++) @(negedge clk);
    chk("R2", "trigger started run", int'(run_active), 1);
    ext_trig = 1'b0;
    repeat (3) @(negedge clk);
    ext_trig = 1'b1;
    wait_idle("R2");
    chk_run("R2", 4, 4);
    repeat (20) @(negedge clk);
    chk("R2", "busy or held trigger ignored", log_n, 4);
    chk("R11", "irq after trigger run", int'(irq), 1);
    rd_chk("R2", 7, cval(7, 7));
    ext_trig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_multi_full();
    t_flag_rules();
    t_single();
    t_multi_grp1();
    t_abort_restart();
    t_cfg_busy();
    t_set_beats_clear();
    t_trigger();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule